// File: doc/BRIEF.md
# Floating-point to integer converter

This block turns a floating-point value of parameterised exponent and fraction width into an integer of parameterised width. It is purely combinational, so the result and its flag follow the input within the same cycle. A mode input picks a signed (two's-complement) or an unsigned result. The block sits beside a datapath that samples the outputs in whatever register stage suits it.

The input is laid out as {sign, biased exponent field, fraction}. The bias is 2^(EXP_W-1)-1. An exponent field of all ones with a zero fraction means infinity, and with a non-zero fraction it means NaN. A field of zero means zero or a subnormal. The block removes the bias and places the significand, with its hidden one, at integer position. Fraction bits below the binary point are discarded. For a signed negative result the magnitude is negated afterwards.

Any case the block cannot convert gives a result of 0 with the invalid flag set. It does not saturate to the integer limits.

Top module: `fp_to_int`

## Requirements
- R1: The outputs are a combinational function of the inputs: a new input value is reflected at the outputs without any clock edge.
- R2: A finite input with magnitude at least 1 that fits the range yields its magnitude truncated toward zero (fraction bits dropped), for both values of `signed_i`.
- R3: With `signed_i`=1, a negative in-range input yields the two's-complement negation of its truncated magnitude.
- R4: With `signed_i`=0, any negative non-zero input yields 0 with `invalid_o`=1.
- R5: A +0 or -0 input (exponent field 0, fraction 0) yields 0 with `invalid_o`=1.
- R6: An input with magnitude below 1 yields 0 with `invalid_o`=1. This covers an unbiased exponent below 0 and every subnormal.
- R7: The largest legal unbiased exponent is INT_W-2 for signed results and INT_W-1 for unsigned results. A larger exponent, or an infinity, yields 0 with `invalid_o`=1. The signed minimum -2^(INT_W-1) is therefore also reported invalid.
- R8: Any NaN input, quiet or signalling, of either sign, yields 0 with `invalid_o`=1.
- R9: Every successful conversion has `invalid_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fp_i | input | 1+EXP_W+MAN_W | Floating-point operand {sign, exponent field, fraction} |
| signed_i | input | 1 | 1: signed two's-complement result, 0: unsigned result |
| int_o | output | INT_W | Converted integer, 0 when invalid |
| invalid_o | output | 1 | Set when the input cannot be converted |

## Verification
The bench builds the converter with a 5-bit exponent, a 10-bit fraction and a 16-bit integer. At these sizes every boundary of the block can be written as a short literal. The largest finite input reaches exactly the unsigned exponent limit, so the bench can check the last legal unsigned exponent next to the first exponent rejected in signed mode. The same setting covers the negative signed extreme, the first value that overflows, and infinity. Truncation of fraction bits is checked both when the hidden one sits above the fraction and when it sits inside it.

// File: rtl/fp_to_int_pkg.sv
package fp_to_int_pkg;
  typedef enum logic [2:0] {
    FC_ZERO,
    FC_SUB,
    FC_NORM,
    FC_INF,
    FC_NAN
  } fp_class_e;
endpackage

// File: rtl/fp_to_int_unpack.sv
module fp_to_int_unpack
  import fp_to_int_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0]   fp_i,
  output logic                   sign_o,
  output fp_class_e              class_o,
  output logic signed [EXP_W:0]  uexp_o,
  output logic [MAN_W:0]         sig_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [EXP_W-1:0] efield;
  logic [MAN_W-1:0] frac;

  always_comb begin
    sign_o = fp_i[EXP_W+MAN_W];
    efield = fp_i[EXP_W+MAN_W-1:MAN_W];
    frac   = fp_i[MAN_W-1:0];
    uexp_o = $signed({1'b0, efield}) - $signed((EXP_W+1)'(BIAS));
    sig_o  = {1'b1, frac};
    if (efield == '0)
      class_o = (frac == '0) ? FC_ZERO : FC_SUB;
    else if (efield == '1)
      class_o = (frac == '0) ? FC_INF : FC_NAN;
    else
      class_o = FC_NORM;
  end
endmodule

// File: rtl/fp_to_int_range.sv
module fp_to_int_range
  import fp_to_int_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int INT_W = 32
) (
  input  logic                   sign_i,
  input  fp_class_e              class_i,
  input  logic signed [EXP_W:0]  uexp_i,
  input  logic                   signed_i,
  output logic                   invalid_o
);
  localparam int MAX_SGN = INT_W - 2;
  localparam int MAX_UNS = INT_W - 1;

  int  ue;
  int  limit;
  logic bad_class;

  always_comb begin
    ue        = int'(uexp_i);
    limit     = signed_i ? MAX_SGN : MAX_UNS;
    bad_class = (class_i != FC_NORM);
    invalid_o = bad_class || (ue < 0) || (ue > limit) || (sign_i && !signed_i);
  end
endmodule

// File: rtl/fp_to_int_align.sv
module fp_to_int_align #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic signed [EXP_W:0]  uexp_i,
  input  logic [MAN_W:0]         sig_i,
  output logic [INT_W-1:0]       mag_o
);
  localparam int SHW  = $clog2(INT_W);
  localparam int WIDE = INT_W + MAN_W;

  int              ue;
  logic            in_rng;
  logic [SHW-1:0]  shamt;
  logic [WIDE-1:0] wide;
  logic            unused_low;

  always_comb begin
    ue         = int'(uexp_i);
    in_rng     = (ue >= 0) && (ue <= INT_W - 1);
    shamt      = in_rng ? SHW'(ue) : '0;
    wide       = WIDE'(sig_i) << shamt;
    mag_o      = wide[MAN_W +: INT_W];
    unused_low = ^wide[MAN_W-1:0];

    // R2: hidden one lands exactly at the exponent position
    if (in_rng) begin
      p_lead_pos_r2: assert (mag_o[shamt] == 1'b1)
        else $error("hidden bit not at exponent position");
      // R2: no bits survive above the leading one
      p_no_high_r2: assert ((mag_o >> shamt) == INT_W'(1))
        else $error("bits above leading one");
    end
  end
endmodule

// File: rtl/fp_to_int.sv
module fp_to_int
  import fp_to_int_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic [EXP_W+MAN_W:0]  fp_i,
  input  logic                  signed_i,
  output logic [INT_W-1:0]      int_o,
  output logic                  invalid_o
);
  logic                  sign;
  fp_class_e             fclass;
  logic signed [EXP_W:0] uexp;
  logic [MAN_W:0]        sig;
  logic [INT_W-1:0]      mag;
  logic                  bad;
  logic                  neg;

  fp_to_int_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
    .fp_i(fp_i), .sign_o(sign), .class_o(fclass), .uexp_o(uexp), .sig_o(sig)
  );

  fp_to_int_range #(.EXP_W(EXP_W), .INT_W(INT_W)) u_range (
    .sign_i(sign), .class_i(fclass), .uexp_i(uexp), .signed_i(signed_i),
    .invalid_o(bad)
  );

  fp_to_int_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_align (
    .uexp_i(uexp), .sig_i(sig), .mag_o(mag)
  );

  always_comb begin
    neg       = signed_i & sign;
    invalid_o = bad;
    if (bad)
      int_o = '0;
    else if (neg)
      int_o = -mag;
    else
      int_o = mag;

    // R9: a successful conversion is never zero
    if (!bad) begin
      p_valid_nonzero_r9: assert (int_o != '0)
        else $error("valid conversion gave zero");
      // R3: negative signed result has its sign bit set
      p_neg_msb_r3: assert (!(neg) || int_o[INT_W-1])
        else $error("negative result lost sign");
      // R7: positive signed result stays below the sign bit
      p_pos_fits_r7: assert (!(signed_i && !sign) || !int_o[INT_W-1])
        else $error("signed positive overflowed");
    end
  end
endmodule

// File: tb/fp_to_int_tb.sv
module fp_to_int_tb;
  localparam int EXP_W = 5;
  localparam int MAN_W = 10;
  localparam int INT_W = 16;
  localparam int NV    = 30;

  logic        clk = 1'b0;
  logic [15:0] fp_i = 16'h0000;
  logic        signed_i = 1'b0;
  logic [15:0] int_o;
  logic        invalid_o;
  int          total = 0;
  int          bad = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  fp_to_int #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_dut (
    .fp_i(fp_i), .signed_i(signed_i), .int_o(int_o), .invalid_o(invalid_o)
  );

  // {fp, signed, expected result, expected invalid, requirement}
  localparam logic [37:0] VEC [NV] = '{
    {16'h3C00, 1'b1, 16'h0001, 1'b0, 4'd2},  // R2 1.0 signed
    {16'h3C00, 1'b0, 16'h0001, 1'b0, 4'd2},  // R2 1.0 unsigned
    {16'h3E00, 1'b0, 16'h0001, 1'b0, 4'd2},  // R2 1.5 truncates
    {16'h4180, 1'b1, 16'h0002, 1'b0, 4'd2},  // R2 2.75
    {16'h43FF, 1'b0, 16'h0003, 1'b0, 4'd2},  // R2 3.998
    {16'h63D0, 1'b1, 16'h03E8, 1'b0, 4'd2},  // R2 1000
    {16'h6801, 1'b0, 16'h0802, 1'b0, 4'd2},  // R2 2050, shift above fraction
    {16'hBE00, 1'b1, 16'hFFFF, 1'b0, 4'd3},  // R3 -1.5 -> -1
    {16'hE3D0, 1'b1, 16'hFC18, 1'b0, 4'd3},  // R3 -1000
    {16'hF7FF, 1'b1, 16'h8010, 1'b0, 4'd3},  // R3 -32752
    {16'hBE00, 1'b0, 16'h0000, 1'b1, 4'd4},  // R4 -1.5 unsigned
    {16'hBC00, 1'b0, 16'h0000, 1'b1, 4'd4},  // R4 -1.0 unsigned
    {16'h0000, 1'b1, 16'h0000, 1'b1, 4'd5},  // R5 +0
    {16'h8000, 1'b0, 16'h0000, 1'b1, 4'd5},  // R5 -0 unsigned
    {16'h8000, 1'b1, 16'h0000, 1'b1, 4'd5},  // R5 -0 signed
    {16'h3800, 1'b1, 16'h0000, 1'b1, 4'd6},  // R6 0.5
    {16'h3BFF, 1'b0, 16'h0000, 1'b1, 4'd6},  // R6 just below 1
    {16'h0001, 1'b1, 16'h0000, 1'b1, 4'd6},  // R6 subnormal
    {16'h83FF, 1'b1, 16'h0000, 1'b1, 4'd6},  // R6 negative subnormal
    {16'h77FF, 1'b1, 16'h7FF0, 1'b0, 4'd7},  // R7 signed exp limit
    {16'h7800, 1'b1, 16'h0000, 1'b1, 4'd7},  // R7 signed overflow
    {16'h7800, 1'b0, 16'h8000, 1'b0, 4'd7},  // R7 unsigned exp limit
    {16'h7BFF, 1'b0, 16'hFFE0, 1'b0, 4'd7},  // R7 largest finite unsigned
    {16'h7BFF, 1'b1, 16'h0000, 1'b1, 4'd7},  // R7 largest finite signed
    {16'hF800, 1'b1, 16'h0000, 1'b1, 4'd7},  // R7 signed minimum
    {16'h7C00, 1'b0, 16'h0000, 1'b1, 4'd7},  // R7 +inf
    {16'hFC00, 1'b1, 16'h0000, 1'b1, 4'd7},  // R7 -inf
    {16'h7E00, 1'b1, 16'h0000, 1'b1, 4'd8},  // R8 quiet NaN
    {16'h7C01, 1'b0, 16'h0000, 1'b1, 4'd8},  // R8 signalling NaN
    {16'hFE00, 1'b1, 16'h0000, 1'b1, 4'd8}   // R8 negative NaN
  };

  task automatic check(input int req, input logic [15:0] exp_res, input logic exp_inv);
    total++;
    if (int_o !== exp_res || invalid_o !== exp_inv) begin
      bad++;
      $display("FAIL R%0d fp=%h signed=%0d: got int=%h inv=%0d, expected int=%h inv=%0d",
               req, fp_i, signed_i, int_o, invalid_o, exp_res, exp_inv);
    end
  endtask

  initial begin
    #1;
    check(5, 16'h0000, 1'b1);  // R5 initial zero input
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fp_i     = VEC[i][37:22];
      signed_i = VEC[i][21];
      #2;
      check(int'(VEC[i][3:0]), VEC[i][20:5], VEC[i][4]);  // R9 via valid rows
    end
    // R1: outputs follow inputs with no clock edge in between
    @(negedge clk);
    fp_i = 16'h3C00; signed_i = 1'b1;
    #1 check(1, 16'h0001, 1'b0);
    fp_i = 16'hE3D0;
    #1 check(1, 16'hFC18, 1'b0);
    signed_i = 1'b0;
    #1 check(1, 16'h0000, 1'b1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule